// File: doc/BRIEF.md
# Timer Event Flag and Request Controller

This block collects the event strobes of one 16-bit timer channel and turns them into latched flags, a single interrupt line to the CPU and level requests to several DMA channels. The strobes come from the counter and from each compare/capture unit. They are a compare match, a capture load, the counter reaching its programmed maximum, and the counter reaching zero. The counting direction mode is also an input, because it decides which counter flag may feed a DMA channel.

Software sees three kinds of register through a small write/read port: a flag register that is cleared by writing ones, an interrupt enable register, and one DMA enable mask for each DMA channel. A flag that is enabled in any DMA mask is reserved for DMA: it does not reach the interrupt line. The DMA channel's one-cycle acknowledge clears it, not software. A capture that lands while the previous capture of the same unit is still flagged also raises an overwrite flag.

Top module: `tmr_evt_top`

## Requirements
- R1: During and straight after reset, every flag, the interrupt enable register and every DMA mask read 0, `irq` is 0 and every `dmaReq` bit is 0.
- R2: The flag layout is: bit 0 counter-at-maximum, bit 1 counter-at-zero, bit 2+m compare/capture of unit m, bit 2+U+m capture overwrite of unit m (U = NUM_UNITS). A compare match or a capture load of unit m sets bit 2+m on the next clock edge.
- R3: A capture load of unit m sets the overwrite bit 2+U+m only if bit 2+m was already 1 before that edge. A compare match never sets an overwrite bit.
- R4: `evtCntMax` sets bit 0 and `evtCntZero` sets bit 1, whatever the counting mode.
- R5: Writing to address 0 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 alone. If a set event for a bit lands in the same cycle as its clear, the bit ends up 1.
- R6: `irq` is 1 exactly when some flag is 1, its interrupt enable bit (address 1, same layout) is 1, and no DMA mask enables that flag.
- R7: `dmaReq[k]` is 1 exactly when some flag is 1 that is enabled in mask k and eligible. Compare/capture bits are always eligible. Bit 0 is eligible when `cntMode` is not 2'b01 (2'b00 up, 2'b10 and 2'b11 up/down). Bit 1 is eligible only when `cntMode` is 2'b01 (down).
- R8: A 1 on `dmaAck[k]` clears exactly the flags that are enabled in mask k and eligible in that cycle. A set event in the same cycle wins over the acknowledge.
- R9: Mask k sits at address 2+k and reads back what was written, except that the overwrite bit positions always read 0. Address 1 reads back the interrupt enable register unchanged.
- R10: Addresses above 1+NUM_DMA read 0, and a write to them changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cntMode | input | 2 | Counting mode: 00 up, 01 down, 10/11 up/down |
| evtCmpMatch | input | NUM_UNITS | Compare match strobe per unit |
| evtCapLoad | input | NUM_UNITS | Capture load strobe per unit |
| evtCntMax | input | 1 | Counter reached its programmed maximum |
| evtCntZero | input | 1 | Counter reached 0x0000 |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | clog2(NUM_DMA+2) | Register address |
| regWrData | input | 2*NUM_UNITS+2 | Register write data |
| regRdData | output | 2*NUM_UNITS+2 | Register read data for `regAddr`, combinational |
| irq | output | 1 | Interrupt request to the CPU |
| dmaReq | output | NUM_DMA | Level request per DMA channel |
| dmaAck | input | NUM_DMA | One-cycle acknowledge per DMA channel |

## Verification
The bench builds the block with three compare/capture units and three DMA channels, which gives an 8-bit flag register and a 3-bit address. Address 5 to 7 are then left unmapped, so writes that must be ignored can be exercised. Three masks let one channel's acknowledge be checked against flags that another channel owns. Three units also move the overwrite bits away from their default positions, so a layout error shows up.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;

  // Width of the mask index carried in the strobe struct (up to 16 DMA channels).
  localparam int SEL_W = 4;

  // Counting mode code for down counting; every other code counts upward.
  localparam logic [1:0] MODE_DOWN = 2'b01;

  // Flag positions that do not depend on the unit count.
  localparam int BIT_MAX  = 0;
  localparam int BIT_ZERO = 1;
  localparam int CMP_LO   = 2;

  typedef enum logic [1:0] {
    SEL_FLAG = 2'd0,
    SEL_IE   = 2'd1,
    SEL_MASK = 2'd2,
    SEL_NONE = 2'd3
  } regSel_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             flagWr;
    logic             ieWr;
    logic             maskWr;
    logic [SEL_W-1:0] maskIdx;
    logic             maxDmaOk;
    logic             zeroDmaOk;
  } ctrlStrb_t;

endpackage

// File: rtl/tmr_evt_ctrl.sv
module tmr_evt_ctrl
  import tmr_evt_pkg::*;
#(
  parameter int NUM_DMA = 2,
  parameter int ADDR_W  = 2
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        cntMode,
  output ctrlStrb_t         strb,
  output regSel_t           rdSel
);

  localparam int MASK_LO  = 2;
  localparam int MASK_END = MASK_LO + NUM_DMA;

  regSel_t          sel;
  logic [SEL_W-1:0] idx;

  // Address decode.
  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (int'(regAddr) == 0) begin
      sel = SEL_FLAG;
    end else if (int'(regAddr) == 1) begin
      sel = SEL_IE;
    end else if (int'(regAddr) < MASK_END) begin
      sel = SEL_MASK;
      idx = SEL_W'(int'(regAddr) - MASK_LO);
    end
  end

  // Strobe assembly: write qualifiers plus mode-dependent DMA eligibility.
  always_comb begin
    strb.flagWr    = regWrEn && (sel == SEL_FLAG);
    strb.ieWr      = regWrEn && (sel == SEL_IE);
    strb.maskWr    = regWrEn && (sel == SEL_MASK);
    strb.maskIdx   = idx;
    strb.maxDmaOk  = (cntMode != MODE_DOWN);
    strb.zeroDmaOk = (cntMode == MODE_DOWN);
  end

  assign rdSel = sel;

endmodule

// File: rtl/tmr_evt_dp.sv
module tmr_evt_dp
  import tmr_evt_pkg::*;
#(
  parameter int NUM_UNITS = 2,
  parameter int NUM_DMA   = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrb_t                   strb,
  input  logic [NUM_UNITS-1:0]        evtCmpMatch,
  input  logic [NUM_UNITS-1:0]        evtCapLoad,
  input  logic                        evtCntMax,
  input  logic                        evtCntZero,
  input  logic [2*NUM_UNITS+1:0]      regWrData,
  input  logic [NUM_DMA-1:0]          dmaAck,
  output logic [2*NUM_UNITS+1:0]      flagState,
  output logic [2*NUM_UNITS+1:0]      ieState,
  output logic [2*NUM_UNITS+1:0]      maskSel,
  output logic                        irq,
  output logic [NUM_DMA-1:0]          dmaReq
);

  localparam int FLAG_W = 2 * NUM_UNITS + 2;
  localparam int OVW_LO = CMP_LO + NUM_UNITS;

  logic [FLAG_W-1:0] flagQ;
  logic [FLAG_W-1:0] ieQ;
  logic [FLAG_W-1:0] setVec;
  logic [FLAG_W-1:0] dmaCapable;
  logic [FLAG_W-1:0] eligVec;
  logic [FLAG_W-1:0] w1cVec;
  logic [FLAG_W-1:0] ackClr;
  logic [FLAG_W-1:0] dmaEnAny;
  logic [FLAG_W-1:0] maskArr  [NUM_DMA];
  logic [FLAG_W-1:0] ackPart  [NUM_DMA];

  // Set events and the static set of flags that can serve DMA.
  assign setVec[BIT_MAX]      = evtCntMax;
  assign setVec[BIT_ZERO]     = evtCntZero;
  assign dmaCapable[BIT_MAX]  = 1'b1;
  assign dmaCapable[BIT_ZERO] = 1'b1;

  for (genvar m = 0; m < NUM_UNITS; m++) begin : gUnit
    assign setVec[CMP_LO+m]     = evtCmpMatch[m] | evtCapLoad[m];
    assign setVec[OVW_LO+m]     = evtCapLoad[m] & flagQ[CMP_LO+m];
    assign dmaCapable[CMP_LO+m] = 1'b1;
    assign dmaCapable[OVW_LO+m] = 1'b0;
  end

  // Eligibility this cycle: counter flags qualified by counting mode.
  always_comb begin
    eligVec           = dmaCapable;
    eligVec[BIT_MAX]  = strb.maxDmaOk;
    eligVec[BIT_ZERO] = strb.zeroDmaOk;
  end

  // Per-channel mask register, request level and acknowledge clear set.
  for (genvar k = 0; k < NUM_DMA; k++) begin : gChan
    logic [FLAG_W-1:0] maskR;
    logic              hitWr;

    assign hitWr = strb.maskWr && (strb.maskIdx == SEL_W'(k));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskR <= '0;
      end else if (hitWr) begin
        maskR <= regWrData & dmaCapable;
      end
    end

    assign maskArr[k] = maskR;
    assign dmaReq[k]  = |(flagQ & maskR & eligVec);
    assign ackPart[k] = dmaAck[k] ? (maskR & eligVec) : '0;
  end

  // Reductions across channels.
  always_comb begin
    ackClr   = '0;
    dmaEnAny = '0;
    maskSel  = '0;
    for (int k = 0; k < NUM_DMA; k++) begin
      ackClr   = ackClr | ackPart[k];
      dmaEnAny = dmaEnAny | maskArr[k];
      if (strb.maskIdx == SEL_W'(k)) begin
        maskSel = maskArr[k];
      end
    end
  end

  assign w1cVec = strb.flagWr ? regWrData : '0;

  // Flag register: clears from software and DMA, then sets win.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
    end else begin
      flagQ <= (flagQ & ~w1cVec & ~ackClr) | setVec;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieQ <= '0;
    end else if (strb.ieWr) begin
      ieQ <= regWrData;
    end
  end

  // Flags owned by a DMA mask never reach the CPU line.
  assign irq       = |(flagQ & ieQ & ~dmaEnAny);
  assign flagState = flagQ;
  assign ieState   = ieQ;

endmodule

// File: rtl/tmr_evt_top.sv
module tmr_evt_top
  import tmr_evt_pkg::*;
#(
  parameter int NUM_UNITS = 2,
  parameter int NUM_DMA   = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [1:0]                      cntMode,
  input  logic [NUM_UNITS-1:0]            evtCmpMatch,
  input  logic [NUM_UNITS-1:0]            evtCapLoad,
  input  logic                            evtCntMax,
  input  logic                            evtCntZero,
  input  logic                            regWrEn,
  input  logic [$clog2(NUM_DMA+2)-1:0]    regAddr,
  input  logic [2*NUM_UNITS+1:0]          regWrData,
  output logic [2*NUM_UNITS+1:0]          regRdData,
  output logic                            irq,
  output logic [NUM_DMA-1:0]              dmaReq,
  input  logic [NUM_DMA-1:0]              dmaAck
);

  localparam int FLAG_W = 2 * NUM_UNITS + 2;
  localparam int ADDR_W = $clog2(NUM_DMA + 2);

  ctrlStrb_t         strb;
  regSel_t           rdSel;
  logic [FLAG_W-1:0] flagState;
  logic [FLAG_W-1:0] ieState;
  logic [FLAG_W-1:0] maskSel;

  tmr_evt_ctrl #(
    .NUM_DMA (NUM_DMA),
    .ADDR_W  (ADDR_W)
  ) uCtrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .cntMode (cntMode),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  tmr_evt_dp #(
    .NUM_UNITS (NUM_UNITS),
    .NUM_DMA   (NUM_DMA)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .evtCmpMatch (evtCmpMatch),
    .evtCapLoad  (evtCapLoad),
    .evtCntMax   (evtCntMax),
    .evtCntZero  (evtCntZero),
    .regWrData   (regWrData),
    .dmaAck      (dmaAck),
    .flagState   (flagState),
    .ieState     (ieState),
    .maskSel     (maskSel),
    .irq         (irq),
    .dmaReq      (dmaReq)
  );

  always_comb begin
    unique case (rdSel)
      SEL_FLAG: regRdData = flagState;
      SEL_IE:   regRdData = ieState;
      SEL_MASK: regRdData = maskSel;
      default:  regRdData = '0;
    endcase
  end

endmodule

// File: rtl/tmr_evt_chk.sv
module tmr_evt_chk #(
  parameter int NUM_UNITS = 2,
  parameter int NUM_DMA   = 2
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [1:0]                   cntMode,
  input logic [NUM_UNITS-1:0]         evtCmpMatch,
  input logic [NUM_UNITS-1:0]         evtCapLoad,
  input logic                         evtCntMax,
  input logic                         evtCntZero,
  input logic                         regWrEn,
  input logic [$clog2(NUM_DMA+2)-1:0] regAddr,
  input logic [2*NUM_UNITS+1:0]       regWrData,
  input logic                         irq,
  input logic [NUM_DMA-1:0]           dmaReq,
  input logic [NUM_DMA-1:0]           dmaAck,
  input logic [2*NUM_UNITS+1:0]       flagState,
  input logic [2*NUM_UNITS+1:0]       ieState
);

  localparam int FLAG_W = 2 * NUM_UNITS + 2;
  localparam int CMP_LO = 2;
  localparam int OVW_LO = CMP_LO + NUM_UNITS;

  logic anySet;
  assign anySet = (|evtCmpMatch) | (|evtCapLoad) | evtCntMax | evtCntZero;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (flagState == '0 && !irq && dmaReq == '0)); // R1

  AST_COUNTER_SET_MAX: assert property (@(posedge clk) disable iff (!rstN)
    evtCntMax |=> flagState[0]); // R4

  AST_COUNTER_SET_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    evtCntZero |=> flagState[1]); // R4

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (|(flagState & ieState))); // R6

  for (genvar m = 0; m < NUM_UNITS; m++) begin : gUnitChk
    AST_CMPCAP_SET: assert property (@(posedge clk) disable iff (!rstN)
      (evtCmpMatch[m] || evtCapLoad[m]) |=> flagState[CMP_LO+m]); // R2

    AST_OVW_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagState[OVW_LO+m]) |-> $past(flagState[CMP_LO+m] && evtCapLoad[m])); // R3
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : gBitChk
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && regAddr == '0 && regWrData[i] && !anySet) |=> !flagState[i]); // R5
  end

  for (genvar k = 0; k < NUM_DMA; k++) begin : gChanChk
    AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rstN)
      (dmaAck[k] && !anySet && !regWrEn) |=> (!dmaReq[k] || cntMode != $past(cntMode))); // R8
  end

endmodule

bind tmr_evt_top tmr_evt_chk #(
  .NUM_UNITS (NUM_UNITS),
  .NUM_DMA   (NUM_DMA)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .cntMode     (cntMode),
  .evtCmpMatch (evtCmpMatch),
  .evtCapLoad  (evtCapLoad),
  .evtCntMax   (evtCntMax),
  .evtCntZero  (evtCntZero),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .regWrData   (regWrData),
  .irq         (irq),
  .dmaReq      (dmaReq),
  .dmaAck      (dmaAck),
  .flagState   (flagState),
  .ieState     (ieState)
);

// File: tb/tb_tmr_evt_top.sv
`timescale 1ns/1ps
module tb_tmr_evt_top;

  localparam int U  = 3;
  localparam int D  = 3;
  localparam int FW = 2 * U + 2;
  localparam int AW = $clog2(D + 2);
  localparam logic [FW-1:0] CAPABLE = 8'b0001_1111;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    cntMode = 2'b00;
  logic [U-1:0]  evtCmpMatch = '0;
  logic [U-1:0]  evtCapLoad = '0;
  logic          evtCntMax = 1'b0;
  logic          evtCntZero = 1'b0;
  logic          regWrEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [FW-1:0] regWrData = '0;
  logic [FW-1:0] regRdData;
  logic          irq;
  logic [D-1:0]  dmaReq;
  logic [D-1:0]  dmaAck = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [FW-1:0] mFlags = '0;
  logic [FW-1:0] mIe = '0;
  logic [FW-1:0] mMask [D];

  logic [FW-1:0] lastRd;
  logic          lastIrq;
  logic [D-1:0]  lastReq;

  always #5 clk = ~clk;

  tmr_evt_top #(.NUM_UNITS(U), .NUM_DMA(D)) dut (
    .clk(clk), .rstN(rstN), .cntMode(cntMode),
    .evtCmpMatch(evtCmpMatch), .evtCapLoad(evtCapLoad),
    .evtCntMax(evtCntMax), .evtCntZero(evtCntZero),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq), .dmaReq(dmaReq), .dmaAck(dmaAck)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] eligOf(logic [1:0] mode);
    logic [FW-1:0] e;
    e = 8'b0001_1100;
    if (mode == 2'b01) e[1] = 1'b1;
    else               e[0] = 1'b1;
    return e;
  endfunction

  function automatic logic [FW-1:0] readOf(logic [AW-1:0] a);
    if (a == 0) return mFlags;
    if (a == 1) return mIe;
    if (int'(a) < D + 2) return mMask[int'(a) - 2];
    return '0;
  endfunction

  // One clock: sample and compare at negedge+1, predict, advance, release strobes.
  task automatic cycle();
    logic [FW-1:0] elig, anyMask, setV, clr, nFlags;
    logic [D-1:0]  expReq;
    logic          expIrq;
    #1;
    lastRd  = regRdData;
    lastIrq = irq;
    lastReq = dmaReq;
    elig    = eligOf(cntMode);
    anyMask = '0;
    for (int k = 0; k < D; k++) begin
      anyMask |= mMask[k];
      expReq[k] = |(mFlags & mMask[k] & elig);
    end
    expIrq = |(mFlags & mIe & ~anyMask);
    chk("R6 irq", 32'(lastIrq), 32'(expIrq));
    chk("R7 dmaReq", 32'(lastReq), 32'(expReq));
    chk((int'(regAddr) >= D + 2) ? "R10 read" : "R9 read", 32'(lastRd), 32'(readOf(regAddr)));
    setV = '0;
    setV[0] = evtCntMax;
    setV[1] = evtCntZero;
    for (int m = 0; m < U; m++) begin
      setV[2+m]   = evtCmpMatch[m] | evtCapLoad[m];
      setV[2+U+m] = evtCapLoad[m] & mFlags[2+m];
    end
    clr = '0;
    for (int k = 0; k < D; k++) if (dmaAck[k]) clr |= mMask[k] & elig;
    if (regWrEn && regAddr == 0) clr |= regWrData;
    nFlags = (mFlags & ~clr) | setV;
    @(posedge clk);
    mFlags = nFlags;
    if (regWrEn && regAddr == 1) mIe = regWrData;
    for (int k = 0; k < D; k++)
      if (regWrEn && int'(regAddr) == k + 2) mMask[k] = regWrData & CAPABLE;
    @(negedge clk);
    evtCmpMatch = '0; evtCapLoad = '0; evtCntMax = 1'b0; evtCntZero = 1'b0;
    regWrEn = 1'b0; dmaAck = '0;
  endtask

  task automatic wr(int a, logic [FW-1:0] d);
    regWrEn = 1'b1; regAddr = AW'(a); regWrData = d;
    cycle();
  endtask

  task automatic rd(int a);
    regAddr = AW'(a);
    cycle();
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    for (int k = 0; k < D; k++) mMask[k] = '0;
    void'($urandom(32'd5150));

    // R1: reset values seen at the ports
    repeat (2) @(negedge clk);
    for (int a = 0; a < D + 2; a++) begin
      @(negedge clk);
      regAddr = AW'(a);
      #1;
      chk("R1 reset read", 32'(regRdData), 32'h0);
    end
    chk("R1 reset irq", 32'(irq), 32'h0);
    chk("R1 reset dmaReq", 32'(dmaReq), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    regAddr = '0;

    // R2: compare match and capture load set the unit flag
    evtCmpMatch[1] = 1'b1; cycle();
    rd(0); chk("R2 cmp match flag", 32'(lastRd), 32'h08);
    evtCapLoad[0] = 1'b1; cycle();
    rd(0); chk("R2 capture flag, R3 no overwrite", 32'(lastRd), 32'h0C);

    // R3: overwrite only for a capture onto a pending flag
    evtCapLoad[0] = 1'b1; cycle();
    rd(0); chk("R3 overwrite set", 32'(lastRd), 32'h2C);
    evtCmpMatch[1] = 1'b1; cycle();
    rd(0); chk("R3 match no overwrite", 32'(lastRd), 32'h2C);

    // R4: counter flags in any mode
    cntMode = 2'b01;
    evtCntMax = 1'b1; cycle();
    evtCntZero = 1'b1; cycle();
    rd(0); chk("R4 max and zero", 32'(lastRd), 32'h2F);

    // R5: write-one-to-clear, zero bits ignored, set wins
    wr(0, 8'h00); rd(0); chk("R5 write zero", 32'(lastRd), 32'h2F);
    wr(0, 8'h21); rd(0); chk("R5 clear ones", 32'(lastRd), 32'h0E);
    evtCapLoad[0] = 1'b1; wr(0, 8'h04);
    rd(0); chk("R5 set beats clear", 32'(lastRd), 32'h2E);

    // R6: interrupt enable and DMA priority
    wr(1, 8'h02); rd(0); chk("R6 irq raised", 32'(lastIrq), 32'h1);
    wr(2, 8'h02); rd(0); chk("R6 irq masked by DMA", 32'(lastIrq), 32'h0);
    chk("R7 zero request down", 32'(lastReq), 32'h1);

    // R7: mode eligibility
    cntMode = 2'b00; rd(0); chk("R7 zero not eligible up", 32'(lastReq), 32'h0);
    cntMode = 2'b01;
    wr(3, 8'h08); rd(0); chk("R7 two channels", 32'(lastReq), 32'h3);

    // R8: acknowledge clears only its own flags; set wins
    dmaAck[1] = 1'b1; cycle();
    rd(0); chk("R8 ack ch1 flags", 32'(lastRd), 32'h26);
    chk("R8 ack ch1 req", 32'(lastReq), 32'h1);
    dmaAck[0] = 1'b1; evtCntZero = 1'b1; cycle();
    rd(0); chk("R8 set beats ack", 32'(lastRd), 32'h26);
    dmaAck[0] = 1'b1; cycle();
    rd(0); chk("R8 ack ch0 flags", 32'(lastRd), 32'h24);
    chk("R8 ack ch0 req", 32'(lastReq), 32'h0);

    // R9: readback of enables and masks
    wr(4, 8'hFF); rd(4); chk("R9 mask readback", 32'(lastRd), 32'h1F);
    rd(1); chk("R9 ie readback", 32'(lastRd), 32'h02);

    // R10: unmapped addresses
    wr(6, 8'hFF); rd(6); chk("R10 unmapped read", 32'(lastRd), 32'h0);
    rd(0); chk("R10 flags untouched", 32'(lastRd), 32'h24);
    rd(1); chk("R10 ie untouched", 32'(lastRd), 32'h02);

    wr(2, 8'h00); wr(3, 8'h00); wr(4, 8'h00); wr(1, 8'h00); wr(0, 8'hFF);

    // Random traffic checked against the bench model
    for (int n = 0; n < 3000; n++) begin
      for (int m = 0; m < U; m++) begin
        evtCmpMatch[m] = ($urandom_range(7) == 0);
        evtCapLoad[m]  = ($urandom_range(7) == 0);
      end
      evtCntMax  = ($urandom_range(7) == 0);
      evtCntZero = ($urandom_range(7) == 0);
      if ($urandom_range(31) == 0) cntMode = 2'($urandom_range(3));
      for (int k = 0; k < D; k++) dmaAck[k] = ($urandom_range(3) == 0);
      regAddr   = AW'($urandom_range(7));
      regWrEn   = ($urandom_range(3) == 0);
      regWrData = FW'($urandom);
      cycle();
    end

    done = 1'b1;
    finishRun();
  end

endmodule